// File: doc/BRIEF.md
# Read-Return Latency Aligner

This block sits beside the read-data capture path of a quad-data-rate SRAM controller. It runs on a clock whose every edge is one half-cycle of the memory clock, so one tick of `clk` is one half-cycle slot on the read bus. When a read is issued, the block schedules the slots in which the returning words will appear. It raises `word_valid` once per returning word and raises `burst_done` with the last word of each burst. Several reads can be in flight at once, so a new read may be issued before an earlier one has returned.

The return delay is set by a latency code: 1.5, 2 or 2.5 memory cycles, which is 3, 4 or 5 ticks. The 1.5-cycle setting is for older parts, which give no valid indicator, so timing there comes from the schedule alone. With the 2 or 2.5-cycle setting the memory drives a one-tick valid indicator in the slot just before each first word. The block compares that indicator with its own schedule and latches a sticky error flag when they disagree.

Top module: `qdr_rd_align`

## Requirements
- R1: A read issued (rd_issue high) in tick c produces its first `word_valid` in tick c+L, where L is 3 for lat_sel=0, 4 for lat_sel=1, and 5 for lat_sel=2 or 3.
- R2: With burst_four=0 a read returns 2 words and with burst_four=1 it returns 4 words, one per tick, on consecutive ticks starting at c+L.
- R3: `burst_done` is high exactly in the tick of the last word of each burst (c+L+N-1 for N words) and low in every other tick.
- R4: Reads issued at least N ticks apart are each tracked on their own, including reads issued before an earlier read has returned, and back-to-back bursts give a continuous run of `word_valid`.
- R5: For lat_sel other than 0, `qvalid_in` is expected high in tick c+L-1 of every read and low in every other tick. Any tick where it differs sets `timing_err`, which is visible in the following tick.
- R6: Once set, `timing_err` stays high until reset.
- R7: For lat_sel=0, `qvalid_in` is ignored and `timing_err` stays low whatever it does.
- R8: A synchronous reset drops every outstanding read and clears `timing_err`. All outputs are low in the tick after reset is sampled, and no word of a dropped read appears later.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle tick clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_issue | input | 1 | Read command issued in this tick |
| burst_four | input | 1 | Burst length select: 0 = two words, 1 = four words |
| lat_sel | input | 2 | Latency code: 0 = 1.5 cycles, 1 = 2 cycles, 2 or 3 = 2.5 cycles |
| qvalid_in | input | 1 | Output-valid indicator from the memory, already sampled |
| word_valid | output | 1 | A returning read word is valid in this tick |
| burst_done | output | 1 | Last word of a burst is in this tick |
| timing_err | output | 1 | Sticky flag: indicator and schedule disagreed |

## Verification
The bench sweeps every latency code against both burst lengths. For each pair it issues an isolated read, followed by back-to-back reads that overlap in flight. A design that counts latency in whole cycles, or that keeps only one outstanding read, would shift or drop words in these runs. The bench moves the indicator one tick early in one run and one tick late in another, and it must see the sticky error latch and hold. In the 1.5-cycle mode it applies the same misplaced indicator and expects the flag to stay clear. A reset in the middle of a four-word burst must cut off the remaining words, so any schedule that survives reset shows up as stray words.

// File: rtl/qdr_align_pkg.sv
package qdr_align_pkg;
  localparam int MAX_LAT_TICKS = 5;
  localparam int MAX_BURST     = 4;
  localparam int SLOT_DEPTH    = MAX_LAT_TICKS + MAX_BURST - 1;
  localparam int SEL_W         = 2;

  typedef logic [SLOT_DEPTH-1:0] slot_vec_t;

  // half-cycle ticks from issue to first word
  function automatic int unsigned lat_ticks(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    return 3;
      2'd1:    return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int unsigned burst_words(input logic four);
    return four ? 4 : 2;
  endfunction

  function automatic logic uses_indicator(input logic [SEL_W-1:0] sel);
    return sel != 2'd0;
  endfunction

  // bits [first, first+count) set
  function automatic slot_vec_t span_mask(input int unsigned first, input int unsigned count);
    slot_vec_t m;
    for (int i = 0; i < SLOT_DEPTH; i++)
      m[i] = (i >= first) && (i < first + count);
    return m;
  endfunction
endpackage

// File: rtl/slot_pipe.sv
module slot_pipe #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [DEPTH-1:0] load_mask,
  output logic             head
);
  logic [DEPTH-1:0] slots;

  always_ff @(posedge clk) begin
    if (rst) slots <= '0;
    else     slots <= (slots >> 1) | (load_en ? load_mask : '0);
  end

  assign head = slots[0];

  // R8
  slot_clear_chk: assert property (@(posedge clk) rst |=> (slots == '0));
endmodule

// File: rtl/lead_check.sv
module lead_check (
  input  logic clk,
  input  logic rst,
  input  logic check_en,
  input  logic lead_expected,
  input  logic indicator,
  output logic err
);
  logic mismatch;

  assign mismatch = check_en && (indicator != lead_expected);

  always_ff @(posedge clk) begin
    if (rst)           err <= 1'b0;
    else if (mismatch) err <= 1'b1;
  end

  // R6
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst) err |=> err);
  // R7
  legacy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!check_en && !err) |=> !err);
endmodule

// File: rtl/qdr_rd_align.sv
module qdr_rd_align
  import qdr_align_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_issue,
  input  logic             burst_four,
  input  logic [SEL_W-1:0] lat_sel,
  input  logic             qvalid_in,
  output logic             word_valid,
  output logic             burst_done,
  output logic             timing_err
);
  localparam int KINDS  = 4;
  localparam int K_WORD = 0;
  localparam int K_LAST = 1;
  localparam int K_FRST = 2;
  localparam int K_LEAD = 3;

  int unsigned lat_n;
  int unsigned words_n;
  slot_vec_t   load_masks [KINDS];
  logic [KINDS-1:0] heads;
  logic first_now;
  logic lead_now;

  always_comb begin
    lat_n   = lat_ticks(lat_sel);
    words_n = burst_words(burst_four);
    load_masks[K_WORD] = span_mask(lat_n - 1, words_n);
    load_masks[K_LAST] = span_mask(lat_n + words_n - 2, 1);
    load_masks[K_FRST] = span_mask(lat_n - 1, 1);
    load_masks[K_LEAD] = span_mask(lat_n - 2, 1);
  end

  for (genvar k = 0; k < KINDS; k++) begin : g_pipe
    slot_pipe #(.DEPTH(SLOT_DEPTH)) u_pipe (
      .clk      (clk),
      .rst      (rst),
      .load_en  (rd_issue),
      .load_mask(load_masks[k]),
      .head     (heads[k])
    );
  end

  assign word_valid = heads[K_WORD];
  assign burst_done = heads[K_LAST];
  assign first_now  = heads[K_FRST];
  assign lead_now   = heads[K_LEAD];

  lead_check u_lead (
    .clk          (clk),
    .rst          (rst),
    .check_en     (uses_indicator(lat_sel)),
    .lead_expected(lead_now),
    .indicator    (qvalid_in),
    .err          (timing_err)
  );

  // R1
  first_word_chk: assert property (@(posedge clk) disable iff (rst)
    first_now |-> word_valid);
  // R3
  done_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
    burst_done |-> word_valid);
  // R5
  lead_then_first_chk: assert property (@(posedge clk) disable iff (rst)
    lead_now |=> first_now);
endmodule

// File: tb/qdr_rd_align_tb.sv
`timescale 1ns/1ps
module qdr_rd_align_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_issue = 1'b0;
  logic burst_four = 1'b0;
  logic [1:0] lat_sel = 2'd0;
  logic qvalid_in = 1'b0;
  logic word_valid, burst_done, timing_err;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  qdr_rd_align u_dut (
    .clk(clk), .rst(rst), .rd_issue(rd_issue), .burst_four(burst_four),
    .lat_sel(lat_sel), .qvalid_in(qvalid_in),
    .word_valid(word_valid), .burst_done(burst_done), .timing_err(timing_err)
  );

  task automatic check(input string tag, input logic act, input logic exp, input int cyc);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  logic ewv [64];
  logic ebd [64];
  logic elead [64];
  logic qvd [64];

  task automatic run_seq(input logic [1:0] sel, input logic b4, input logic [63:0] iss,
                         input int off, input int rst_at);
    int lat, nw, err_m;
    lat = (sel > 2'd2) ? 5 : 3 + int'(sel);
    nw  = b4 ? 4 : 2;
    for (int i = 0; i < 64; i++) begin
      ewv[i] = 0; ebd[i] = 0; elead[i] = 0; qvd[i] = 0;
    end
    for (int c = 0; c < 40; c++) begin
      if (iss[c]) begin
        for (int i = 0; i < nw; i++)
          if (rst_at < 0 || c + lat + i <= rst_at) ewv[c+lat+i] = 1;
        if (rst_at < 0 || c + lat + nw - 1 <= rst_at) ebd[c+lat+nw-1] = 1;
        if (rst_at < 0 || c + lat - 1 <= rst_at) elead[c+lat-1] = 1;
        if (rst_at < 0 || c + lat - 1 + off <= rst_at) qvd[c+lat-1+off] = 1;
      end
    end
    // reset and check cleared state (R8)
    rst = 1; rd_issue = 0; qvalid_in = 0; lat_sel = sel; burst_four = b4;
    @(negedge clk);
    @(negedge clk);
    check("R8 reset word_valid", word_valid, 1'b0, -1);
    check("R8 reset burst_done", burst_done, 1'b0, -1);
    check("R8 reset timing_err", timing_err, 1'b0, -1);
    rst = 0;
    err_m = 0;
    for (int n = 0; n < 48; n++) begin
      @(negedge clk);
      check("R1 R2 R4 R8 word_valid", word_valid, ewv[n], n);
      check("R3 burst_done", burst_done, ebd[n], n);
      check("R5 R6 R7 timing_err", timing_err, err_m[0], n);
      rd_issue  = iss[n];
      qvalid_in = qvd[n];
      rst       = (n == rst_at);
      if (n == rst_at) err_m = 0;
      else if (sel != 2'd0 && qvd[n] != elead[n]) err_m = 1;
    end
    rst = 0; rd_issue = 0; qvalid_in = 0;
  endtask

  task automatic finish_report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20.0 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_report();
  end

  initial begin
    // R1 R2 R3 R4: every latency code with both burst lengths, single and overlapped reads
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 2; b++) begin
        logic [63:0] pat;
        int nw;
        nw = b ? 4 : 2;
        pat = '0;
        pat[2] = 1; pat[12] = 1; pat[12+nw] = 1; pat[12+2*nw] = 1;
        run_seq(2'(s), 1'(b), pat, 0, -1);
      end
    end
    // R5 R6: indicator one tick early in 2-cycle mode, one tick late in 2.5-cycle mode
    run_seq(2'd1, 1'b0, 64'h1004, -1, -1);
    run_seq(2'd2, 1'b1, 64'h1004, 1, -1);
    // R7: misplaced indicator ignored in 1.5-cycle mode
    run_seq(2'd0, 1'b1, 64'h1004, -1, -1);
    // R8: reset in the middle of a four-word burst drops the remainder
    run_seq(2'd2, 1'b1, 64'h4, 0, 8);
    finish_report();
  end
endmodule